// File: doc/BRIEF.md
# Shared-Pin External Interrupt Combiner

Software can route several general-purpose pins to a single external interrupt channel. This block takes the raw levels of those pins and turns them into one interrupt request. It also takes a per-pin select mask, a trigger-mode bit and a polarity bit. Every pin first passes through a multi-flop synchroniser. The synchronised levels are made available so that an interrupt handler can read them and find out which pin caused the request.

The pins are combined differently in each mode. In level mode the request follows the selected pins with no memory. With low polarity the request is active while any selected pin is low. With high polarity it is active while any selected pin is high. In edge mode only the selected pin with the lowest index is watched. The polarity bit chooses between a falling and a rising edge, and a detected edge sets a sticky pending flag. That flag stays set until a one-cycle clear pulse arrives. Selecting more than one pin in edge mode counts as a configuration error and is flagged on a separate output. Any change to the mode, the polarity or the select mask drops the pending flag and re-arms the detector, so the change itself cannot produce an edge.

Top module: `eint_combiner`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `irq`, `cfg_err` and `pin_level` are all 0.
- R2: `pin_level` shows `pin_in` delayed by the synchroniser. A pin change driven before rising edge k is visible after edge k+1.
- R3: With `mode`=0 (level) and `pol`=0 (low), `irq` is 1 exactly when at least one pin whose `sel` bit is 1 is low. It updates on the edge after the synchronised level changes, which is three edges after a pin change.
- R4: With `mode`=0 and `pol`=1 (high), `irq` is 1 exactly when at least one pin whose `sel` bit is 1 is high, with the same latency as R3.
- R5: In level mode `irq` is not latched. It drops when the combined level goes inactive, and a `clr` pulse leaves it unchanged.
- R6: With `mode`=1 (edge), only the selected pin with the lowest index can set `irq`. Edges on other selected pins are ignored whatever the polarity. `pol`=0 detects a falling edge and `pol`=1 detects a rising edge, and the edge sets `irq` three edges after the pin change.
- R7: In edge mode `irq` stays 1 until `clr` is high at a rising edge. It then reads 0 after that edge.
- R8: If a qualifying edge is detected at the same rising edge where `clr` is high, `irq` is 1 afterwards.
- R9: When `sel` is all zeros, `irq` stays 0 in both modes.
- R10: `cfg_err` is 1 one edge after `mode`=1 is sampled together with two or more `sel` bits set, and 0 otherwise.
- R11: In edge mode, a change of `mode`, `pol` or `sel` clears `irq` at the edge where the change is sampled. The change itself does not set `irq`, even if the level of the watched pin differs from before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_in | input | NPINS | Raw, asynchronous pin levels |
| sel | input | NPINS | Pins routed to this channel (1 = routed) |
| mode | input | 1 | 0 = level trigger, 1 = edge trigger |
| pol | input | 1 | 0 = low / falling, 1 = high / rising |
| clr | input | 1 | One-cycle clear of the edge-mode pending flag |
| irq | output | 1 | Registered interrupt request |
| cfg_err | output | 1 | Registered flag: edge mode with more than one pin selected |
| pin_level | output | NPINS | Synchronised pin levels |

## Verification
Level mode is swept over every select mask against every pin pattern of a four-pin instance, in both polarities. This separates an any-selected test from an all-selected test and catches masking mistakes. The sweep also checks that a clear pulse leaves the request alone. Edge mode is swept over every mask, with each pin toggled in turn to its active direction. This shows whether the lowest selected pin alone reaches the request, whether the flag stays sticky, and whether a clear removes it. Directed sequences then try an edge landing together with a clear, and polarity, mask and mode changes on a held pin. These show that configuration changes neither leave a stale flag nor produce a false edge.

// File: rtl/eint_pkg.sv
package eint_pkg;
  typedef enum logic {
    TRIG_LEVEL = 1'b0,
    TRIG_EDGE  = 1'b1
  } trig_e;

  typedef struct packed {
    trig_e md;
    logic  hi;   // 1: high level / rising edge
  } trig_cfg_t;
endpackage

// File: rtl/eint_sync.sv
module eint_sync #(
  parameter int WIDTH  = 8,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= '0;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/eint_lowest_pick.sv
module eint_lowest_pick #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] sel,
  input  logic [WIDTH-1:0] lvl,
  output logic             pick_lvl,
  output logic             any_sel,
  output logic             multi_sel
);
  // below[i] is set when some pin with index < i is selected
  logic [WIDTH:0]   below;
  logic [WIDTH-1:0] first;

  assign below[0] = 1'b0;
  for (genvar i = 0; i < WIDTH; i++) begin : g_chain
    assign below[i+1] = below[i] | sel[i];
  end

  assign first     = sel & ~below[WIDTH-1:0];
  assign pick_lvl  = |(first & lvl);
  assign any_sel   = below[WIDTH];
  assign multi_sel = |(sel & below[WIDTH-1:0]);
endmodule

// File: rtl/eint_edge_track.sv
module eint_edge_track (
  input  logic clk,
  input  logic rst,
  input  logic edge_en,
  input  logic rise,
  input  logic cur_lvl,
  input  logic src_valid,
  input  logic rearm,
  input  logic clr,
  output logic pend_nxt
);
  logic prev_lvl;
  logic pend;
  logic hit;

  always_comb begin
    hit = 1'b0;
    if (edge_en && src_valid && !rearm)
      hit = rise ? (cur_lvl & ~prev_lvl) : (~cur_lvl & prev_lvl);

    if (!edge_en || rearm) pend_nxt = 1'b0;
    else if (hit)          pend_nxt = 1'b1;   // edge beats clear
    else if (clr)          pend_nxt = 1'b0;
    else                   pend_nxt = pend;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_lvl <= 1'b0;
      pend     <= 1'b0;
    end else begin
      prev_lvl <= cur_lvl;
      pend     <= pend_nxt;
    end
  end
endmodule

// File: rtl/eint_combiner.sv
module eint_combiner
  import eint_pkg::*;
#(
  parameter int NPINS       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NPINS-1:0] pin_in,
  input  logic [NPINS-1:0] sel,
  input  logic             mode,
  input  logic             pol,
  input  logic             clr,
  output logic             irq,
  output logic             cfg_err,
  output logic [NPINS-1:0] pin_level
);
  logic [NPINS-1:0] lvl;
  logic [NPINS-1:0] sel_q;
  trig_cfg_t        cfg_now, cfg_q;
  logic             cfg_chg;
  logic             pick_lvl, any_sel, multi_sel;
  logic             lvl_hit, pend_nxt;
  logic             irq_q, err_q;

  eint_sync #(.WIDTH(NPINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (pin_in),
    .q   (lvl)
  );

  assign cfg_now.md = trig_e'(mode);
  assign cfg_now.hi = pol;

  // configuration shadows follow the inputs even in reset
  always_ff @(posedge clk) begin
    cfg_q <= cfg_now;
    sel_q <= sel;
  end

  assign cfg_chg = (cfg_now != cfg_q) || (sel != sel_q);

  eint_lowest_pick #(.WIDTH(NPINS)) u_pick (
    .sel       (sel),
    .lvl       (lvl),
    .pick_lvl  (pick_lvl),
    .any_sel   (any_sel),
    .multi_sel (multi_sel)
  );

  eint_edge_track u_edge (
    .clk       (clk),
    .rst       (rst),
    .edge_en   (cfg_now.md == TRIG_EDGE),
    .rise      (cfg_now.hi),
    .cur_lvl   (pick_lvl),
    .src_valid (any_sel),
    .rearm     (cfg_chg),
    .clr       (clr),
    .pend_nxt  (pend_nxt)
  );

  assign lvl_hit = cfg_now.hi ? |(sel & lvl) : |(sel & ~lvl);

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_q <= 1'b0;
      err_q <= 1'b0;
    end else begin
      irq_q <= (cfg_now.md == TRIG_EDGE) ? pend_nxt : lvl_hit;
      err_q <= (cfg_now.md == TRIG_EDGE) && multi_sel;
    end
  end

  assign irq       = irq_q;
  assign cfg_err   = err_q;
  assign pin_level = lvl;
endmodule

// File: rtl/eint_combiner_chk.sv
module eint_combiner_chk #(
  parameter int NPINS = 8
) (
  input logic             clk,
  input logic             rst,
  input logic [NPINS-1:0] sel,
  input logic             mode,
  input logic             pol,
  input logic             clr,
  input logic             irq,
  input logic             cfg_err,
  input logic [NPINS-1:0] pin_level
);
  // R9
  sel_empty_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (sel == '0) |=> !irq);

  // R3
  level_low_chk: assert property (@(posedge clk) disable iff (rst)
    (!mode && !pol) |=> (irq == |($past(sel) & ~$past(pin_level))));

  // R4
  level_high_chk: assert property (@(posedge clk) disable iff (rst)
    (!mode && pol) |=> (irq == |($past(sel) & $past(pin_level))));

  // R7
  pending_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (mode && $stable(mode) && $stable(pol) && $stable(sel) && irq && !clr) |=> irq);

  // R11
  cfg_flip_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (mode && (!$stable(pol) || !$stable(sel) || !$stable(mode))) |=> !irq);

  // R10
  cfg_err_track_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (cfg_err == ($past(mode) && ($countones($past(sel)) > 1))));
endmodule

bind eint_combiner eint_combiner_chk #(.NPINS(NPINS)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .sel       (sel),
  .mode      (mode),
  .pol       (pol),
  .clr       (clr),
  .irq       (irq),
  .cfg_err   (cfg_err),
  .pin_level (pin_level)
);

// File: tb/tb_eint_combiner.sv
`timescale 1ns/1ps
module tb_eint_combiner;
  localparam int NP = 4;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [NP-1:0] pin_in = '0;
  logic [NP-1:0] sel = '0;
  logic          mode = 1'b0;
  logic          pol = 1'b0;
  logic          clr = 1'b0;
  logic          irq, cfg_err;
  logic [NP-1:0] pin_level;

  int n_chk  = 0;
  int n_fail = 0;
  int cycles = 0;

  always #2.5 clk = ~clk;

  eint_combiner #(.NPINS(NP), .SYNC_STAGES(2)) dut (
    .clk(clk), .rst(rst), .pin_in(pin_in), .sel(sel), .mode(mode),
    .pol(pol), .clr(clr), .irq(irq), .cfg_err(cfg_err), .pin_level(pin_level)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      n_fail = n_fail + 1;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk + 1);
      $finish;
    end
  end

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic int lowest(input logic [NP-1:0] s);
    for (int i = 0; i < NP; i++) if (s[i]) return i;
    return -1;
  endfunction

  function automatic int ones(input logic [NP-1:0] s);
    int c = 0;
    for (int i = 0; i < NP; i++) c += s[i];
    return c;
  endfunction

  task automatic pulse_clr();
    clr = 1'b1; step(1); clr = 1'b0;
  endtask

  initial begin
    // R1: reset holds everything at zero
    pin_in = '1; sel = '1; mode = 1'b1; pol = 1'b1;
    step(4);
    check("R1 irq", irq, 0);
    check("R1 cfg_err", cfg_err, 0);
    check("R1 pin_level", pin_level, 0);
    pin_in = '0; sel = '0; mode = 1'b0; pol = 1'b0;
    rst = 1'b0;
    step(1);
    check("R1 irq after release", irq, 0);
    check("R1 pin_level after release", pin_level, 0);

    // R2, R3, R4, R5, R9: level-mode sweep
    mode = 1'b0;
    for (int p = 0; p < 2; p++) begin
      for (int s = 0; s < 16; s++) begin
        for (int v = 0; v < 16; v++) begin
          logic e;
          pol = p[0]; sel = s[NP-1:0]; pin_in = v[NP-1:0];
          e = p[0] ? |(sel & pin_in) : |(sel & ~pin_in);
          step(3);
          check(p ? "R4 level high" : "R3 level low", irq, e);
          if (s == 0) check("R9 empty level", irq, 0);
          check("R2 pin_level", pin_level, v);
          pulse_clr();
          check("R5 clr ignored in level", irq, e);
        end
      end
    end

    // R5: request drops with the level
    pol = 1'b1; sel = 4'b0100; pin_in = 4'b0100; step(3);
    check("R5 level active", irq, 1);
    pin_in = 4'b0000; step(3);
    check("R5 level not latched", irq, 0);

    // R6, R7, R9, R10: edge-mode sweep
    mode = 1'b1;
    for (int p = 0; p < 2; p++) begin
      for (int s = 0; s < 16; s++) begin
        for (int j = 0; j < NP; j++) begin
          logic [NP-1:0] inact;
          logic e;
          inact = p ? '0 : '1;
          pol = p[0]; sel = s[NP-1:0]; pin_in = inact;
          step(5);
          pulse_clr();
          check("R7 cleared", irq, 0);
          check("R10 cfg_err", cfg_err, ones(sel) > 1);
          e = (s != 0) && (lowest(sel) == j);
          pin_in = inact ^ (NP'(1) << j);
          step(3);
          check(s == 0 ? "R9 empty edge" : "R6 lowest pin edge", irq, e);
          step(4);
          check("R7 sticky", irq, e);
          pin_in = inact; step(3);
          check("R7 return edge ignored", irq, e);
          pulse_clr();
          check("R7 clear", irq, 0);
        end
      end
    end

    // R10: level mode never flags error
    mode = 1'b0; sel = '1; step(1);
    check("R10 level no error", cfg_err, 0);

    // R8: edge and clear at the same edge
    mode = 1'b1; pol = 1'b1; sel = 4'b0001; pin_in = '0;
    step(5); pulse_clr();
    pin_in = 4'b0001; step(2);
    clr = 1'b1; step(1); clr = 1'b0;
    check("R8 edge beats clear", irq, 1);
    pulse_clr();
    check("R7 clear after R8", irq, 0);

    // R11: polarity change drops pending, no false edge
    pin_in = '0; step(5); pulse_clr();
    pin_in = 4'b0001; step(3);
    check("R11 setup pending", irq, 1);
    pol = 1'b0; step(1);
    check("R11 pol change clears", irq, 0);
    step(4);
    check("R11 no edge from pol change", irq, 0);

    // R11: select change moves to a pin at a different level
    pol = 1'b1; sel = 4'b0001; pin_in = 4'b0010;
    step(5); pulse_clr();
    sel = 4'b0010; step(5);
    check("R11 no edge from sel change", irq, 0);

    // R11: level to edge switch with active pin
    mode = 1'b0; pol = 1'b1; sel = 4'b0001; pin_in = 4'b0001; step(3);
    check("R11 level active before switch", irq, 1);
    mode = 1'b1; step(1);
    check("R11 mode change clears", irq, 0);
    step(4);
    check("R11 no edge from mode change", irq, 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule